// File: doc/BRIEF.md
# Instruction Namespace Selector Register

This block holds the control register that tells the instruction decoder which meaning to give the 16-bit compressed opcode space. The meaning is a 3-bit binary code in bits 3:1 of the register, so eight alternative encodings can be addressed. Code 0 is the standard compressed set, code 1 the second compressed variant, code 2 a pure 16-bit instruction set, and codes 3 to 7 are kept for custom re-encodings. An 8-bit parameter mask states which codes this build supports.

Software reads and writes the register through a simple register port. Unprivileged code may write it, and the new code drives the decoder from the next cycle with no stall, so code can switch back and forth quickly. A write with an unsupported value is never adjusted. It raises an illegal-write flag for the trap logic and leaves every register as it was.

Each trap vector has its own entry in a table of handler codes, and the entries sit at their own register addresses. On trap entry the active code is moved into a saved-code register and the entry picked by the trap cause becomes active. On trap return the saved code comes back, so the interrupted code never switches back by itself.

Top module: `nsel_csr`

## Requirements
- R1: After reset the active code, the saved code and every table entry read as zero, and `ns_sel` is 0.
- R2: A read at address 0 returns the active code in bits 3:1 and zero in all other bits. Address 1 returns the saved code and address 2+i returns table entry i in the same layout.
- R3: A legal write to address 0 shows on `ns_sel` and in a read-back from the next clock edge.
- R4: A write whose code (bits 3:1) has a clear bit in `LEGAL_MASK` (default 8'h07: codes 0, 1 and 2) raises `illegal_wr` in the same cycle and changes no register.
- R5: A write with bit 0 or any bit above bit 3 set is illegal, raises `illegal_wr` and changes no register.
- R6: Legal writes on consecutive cycles each take effect one cycle later, with no lost write and no stall.
- R7: Table entry i is written at address 2+i and is checked the same way as the active code. An illegal value raises `illegal_wr` and leaves the entry unchanged.
- R8: When `trap_enter` is high, the active code moves into the saved-code register and table entry `trap_cause` becomes the active code.
- R9: When `trap_exit` is high (and `trap_enter` is low), the saved code becomes the active code again.
- R10: A write in the same cycle as `trap_enter` or `trap_exit` is discarded and does not raise `illegal_wr`. The trap update happens as usual.
- R11: A write to address 1 (saved code) or to an unmapped address raises `illegal_wr` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe |
| csr_addr | input | ADDR_W | Register address (0 active, 1 saved, 2+i table) |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for `csr_addr` (combinational) |
| illegal_wr | output | 1 | Write rejected in this cycle |
| trap_enter | input | 1 | Trap entry event |
| trap_cause | input | $clog2(NUM_VEC) | Vector index of the trap |
| trap_exit | input | 1 | Trap return event |
| ns_sel | output | 3 | Active compressed-space code to the decoder |

## Verification
If the active code goes wrong, `ns_sel` shows it to the decoder on the very next cycle, and a read at address 0 shows the same value. A lost or corrupted saved code only shows at the next trap return, when `ns_sel` takes the wrong value. Reading address 1 right after trap entry therefore exposes it earlier. A bad table entry stays hidden until a trap with that cause arrives, so the bench reads every entry it writes back at once and also runs a trap through one of them.

// File: rtl/nsel_pkg.sv
package nsel_pkg;
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = 1;
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [CODE_W-1:0] {
    CODE_STD_C  = 3'd0,
    CODE_ALT_C  = 3'd1,
    CODE_PURE16 = 3'd2
  } std_code_e;
endpackage

// File: rtl/nsel_rst_sync.sv
module nsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q      <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      stg_q      <= 1'b1;
      rst_core_n <= stg_q;
    end
  end
endmodule

// File: rtl/nsel_wr_check.sv
module nsel_wr_check
  import nsel_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  LEGAL_MASK = 8'h07
) (
  input  logic [DATA_W-1:0] wdata,
  output code_t             code,
  output logic              legal
);
  logic pad_ok;

  always_comb begin
    code   = wdata[CODE_MSB:CODE_LSB];
    pad_ok = (wdata[0] == 1'b0) && (wdata[DATA_W-1:CODE_MSB+1] == '0);
    legal  = pad_ok && LEGAL_MASK[code];
  end
endmodule

// File: rtl/nsel_trap_tbl.sv
module nsel_trap_tbl
  import nsel_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  code_t            wr_code,
  input  logic [IDX_W-1:0] trap_idx,
  output code_t            trap_code,
  input  logic [IDX_W-1:0] rd_idx,
  output code_t            rd_code
);
  code_t ent [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    code_t ent_q;
    logic  ent_en;

    assign ent_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= wr_code;
    end

    assign ent[g] = ent_q;
  end

  assign trap_code = ent[trap_idx];
  assign rd_code   = ent[rd_idx];
endmodule

// File: rtl/nsel_csr.sv
module nsel_csr
  import nsel_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         ADDR_W     = 4,
  parameter int         NUM_VEC    = 8,
  parameter logic [7:0] LEGAL_MASK = 8'h07
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csr_we,
  input  logic [ADDR_W-1:0]          csr_addr,
  input  logic [DATA_W-1:0]          csr_wdata,
  output logic [DATA_W-1:0]          csr_rdata,
  output logic                       illegal_wr,
  input  logic                       trap_enter,
  input  logic [$clog2(NUM_VEC)-1:0] trap_cause,
  input  logic                       trap_exit,
  output logic [2:0]                 ns_sel
);
  localparam int IDX_W    = $clog2(NUM_VEC);
  localparam int ADR_ACT  = 0;
  localparam int ADR_SAVE = 1;
  localparam int TBL_BASE = 2;
  localparam int TBL_LAST = TBL_BASE + NUM_VEC - 1;

  function automatic logic [DATA_W-1:0] place(code_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CODE_MSB:CODE_LSB] = c;
    return v;
  endfunction

  logic             rst_core_n;
  code_t            sel_q, sel_d, last_q, last_d;
  logic             sel_en;
  code_t            wr_code, tbl_trap_code, tbl_rd_code;
  logic             wr_legal, hit_act, hit_save, hit_tbl, trap_any, wr_ok;
  logic [IDX_W-1:0] tbl_idx;

  nsel_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  nsel_wr_check #(
    .DATA_W     (DATA_W),
    .LEGAL_MASK (LEGAL_MASK)
  ) i_wr_check (
    .wdata (csr_wdata),
    .code  (wr_code),
    .legal (wr_legal)
  );

  always_comb begin
    hit_act  = (csr_addr == ADDR_W'(ADR_ACT));
    hit_save = (csr_addr == ADDR_W'(ADR_SAVE));
    hit_tbl  = (csr_addr >= ADDR_W'(TBL_BASE)) && (csr_addr <= ADDR_W'(TBL_LAST));
    tbl_idx  = IDX_W'(csr_addr - ADDR_W'(TBL_BASE));
    trap_any = trap_enter || trap_exit;
    wr_ok    = csr_we && !trap_any && wr_legal && (hit_act || hit_tbl);
    illegal_wr = csr_we && !trap_any && !(wr_legal && (hit_act || hit_tbl));
  end

  nsel_trap_tbl #(
    .NUM_VEC (NUM_VEC),
    .IDX_W   (IDX_W)
  ) i_trap_tbl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_ok && hit_tbl),
    .wr_idx    (tbl_idx),
    .wr_code   (wr_code),
    .trap_idx  (trap_cause),
    .trap_code (tbl_trap_code),
    .rd_idx    (tbl_idx),
    .rd_code   (tbl_rd_code)
  );

  // next state: trap entry, then trap return, then software write
  always_comb begin
    sel_d  = sel_q;
    last_d = last_q;
    sel_en = 1'b0;
    if (trap_enter) begin
      last_d = sel_q;
      sel_d  = tbl_trap_code;
      sel_en = 1'b1;
    end else if (trap_exit) begin
      sel_d  = last_q;
      sel_en = 1'b1;
    end else if (wr_ok && hit_act) begin
      sel_d  = wr_code;
      sel_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sel_q  <= '0;
      last_q <= '0;
    end else begin
      if (sel_en)     sel_q  <= sel_d;
      if (trap_enter) last_q <= last_d;
    end
  end

  always_comb begin
    if (hit_act)       csr_rdata = place(sel_q);
    else if (hit_save) csr_rdata = place(last_q);
    else if (hit_tbl)  csr_rdata = place(tbl_rd_code);
    else               csr_rdata = '0;
  end

  assign ns_sel = sel_q;
endmodule

// File: rtl/nsel_csr_chk.sv
module nsel_csr_chk #(
  parameter int         ADDR_W     = 4,
  parameter logic [7:0] LEGAL_MASK = 8'h07
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [2:0]        wr_code,
  input logic              trap_enter,
  input logic              trap_exit,
  input logic              illegal_wr,
  input logic [2:0]        ns_sel,
  input logic [2:0]        last_q
);
  p_legal_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && (csr_addr == '0) && !illegal_wr && !trap_enter && !trap_exit
    |=> ns_sel == $past(wr_code));

  p_illegal_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> $stable(ns_sel) && $stable(last_q));

  p_only_supported_r4: assert property (@(posedge clk) disable iff (!rst_n)
    LEGAL_MASK[ns_sel]);

  p_enter_saves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> last_q == $past(ns_sel));

  p_exit_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_exit && !trap_enter |=> ns_sel == $past(last_q));

  p_trap_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter || trap_exit) |-> !illegal_wr);
endmodule

bind nsel_csr nsel_csr_chk #(
  .ADDR_W     (ADDR_W),
  .LEGAL_MASK (LEGAL_MASK)
) i_nsel_csr_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .csr_we     (csr_we),
  .csr_addr   (csr_addr),
  .wr_code    (csr_wdata[3:1]),
  .trap_enter (trap_enter),
  .trap_exit  (trap_exit),
  .illegal_wr (illegal_wr),
  .ns_sel     (ns_sel),
  .last_q     (last_q)
);

// File: tb/test_nsel_csr.sv
module test_nsel_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_we = 1'b0;
  logic [3:0] csr_addr = '0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic       illegal_wr;
  logic       trap_enter = 1'b0;
  logic [2:0] trap_cause = '0;
  logic       trap_exit = 1'b0;
  logic [2:0] ns_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsel_csr i_nsel_csr (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .illegal_wr, .trap_enter, .trap_cause, .trap_exit, .ns_sel
  );

  // {addr, wdata, expected illegal, expected ns_sel after the edge}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd0, 8'h02, 1'b0, 3'd1},
    {4'd0, 8'h04, 1'b0, 3'd2},
    {4'd0, 8'h06, 1'b1, 3'd2},
    {4'd0, 8'h03, 1'b1, 3'd2},
    {4'd0, 8'h10, 1'b1, 3'd2},
    {4'd0, 8'h00, 1'b0, 3'd0},
    {4'd0, 8'h0E, 1'b1, 3'd0},
    {4'd0, 8'h02, 1'b0, 3'd1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  // one write cycle: check the flag before the edge, the code after it
  task automatic wr(input logic [3:0] a, input logic [7:0] d,
                    input logic exp_ill, input logic [2:0] exp_sel, input string req);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    #1;
    chk({req, " flag"}, {7'd0, illegal_wr}, {7'd0, exp_ill});
    @(posedge clk);
    #1;
    csr_we = 1'b0;
    chk({req, " sel"}, {5'd0, ns_sel}, {5'd0, exp_sel});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 ns_sel", {5'd0, ns_sel}, 8'h00);
    rd(4'd0, "R1 active", 8'h00);
    rd(4'd1, "R1 saved", 8'h00);
    rd(4'd2, "R1 table0", 8'h00);

    // R3 R4 R5 R6: back-to-back vector walk, with R2 read-back after
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][15:12], VEC[i][11:4], VEC[i][3], VEC[i][2:0], "R3/R4/R5/R6 vec");
    end
    rd(4'd0, "R2 readback", 8'h02);

    // R6: two legal writes on consecutive cycles
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 4'd0; csr_wdata = 8'h04;
    @(negedge clk);
    chk("R6 first", {5'd0, ns_sel}, 8'h02);
    csr_wdata = 8'h00;
    @(negedge clk);
    chk("R6 second", {5'd0, ns_sel}, 8'h00);
    csr_wdata = 8'h02;
    @(negedge clk);
    csr_we = 1'b0;
    chk("R6 third", {5'd0, ns_sel}, 8'h01);

    // R7: table writes
    wr(4'd7, 8'h04, 1'b0, 3'd1, "R7 legal entry5");
    rd(4'd7, "R7 entry5", 8'h04);
    wr(4'd3, 8'h0C, 1'b1, 3'd1, "R7 illegal entry1");
    rd(4'd3, "R7 entry1 kept", 8'h00);

    // R11: saved-code and unmapped addresses
    wr(4'd1, 8'h02, 1'b1, 3'd1, "R11 saved addr");
    rd(4'd1, "R11 saved kept", 8'h00);
    wr(4'd15, 8'h00, 1'b1, 3'd1, "R11 unmapped");

    // R8: trap entry through entry 5
    @(negedge clk);
    trap_enter = 1'b1; trap_cause = 3'd5;
    @(negedge clk);
    trap_enter = 1'b0;
    chk("R8 sel", {5'd0, ns_sel}, 8'h02);
    rd(4'd1, "R8 saved", 8'h02);

    // R9: trap return
    @(negedge clk);
    trap_exit = 1'b1;
    @(negedge clk);
    trap_exit = 1'b0;
    chk("R9 sel", {5'd0, ns_sel}, 8'h01);

    // R10: trap entry and write in one cycle
    @(negedge clk);
    trap_enter = 1'b1; trap_cause = 3'd0;
    csr_we = 1'b1; csr_addr = 4'd0; csr_wdata = 8'h04;
    #1;
    chk("R10 flag", {7'd0, illegal_wr}, 8'h00);
    @(negedge clk);
    trap_enter = 1'b0; csr_we = 1'b0;
    chk("R10 sel", {5'd0, ns_sel}, 8'h00);
    rd(4'd1, "R10 saved", 8'h02);

    // R10: illegal write during trap return is discarded without flag
    @(negedge clk);
    trap_exit = 1'b1; csr_we = 1'b1; csr_addr = 4'd0; csr_wdata = 8'h0E;
    #1;
    chk("R10 exit flag", {7'd0, illegal_wr}, 8'h00);
    @(negedge clk);
    trap_exit = 1'b0; csr_we = 1'b0;
    chk("R9/R10 exit sel", {5'd0, ns_sel}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule